// File: doc/BRIEF.md
# Tagged Event Word Formatter

This block turns one trigger into a complete event on a 21-bit word stream. It serves two front-end data sources. When a trigger arrives while the block is idle, it captures each source's channel hit bitmap and an 8-bit event sync number. It then emits, in order: a trigger marker, a header, the bitmaps of both sources, and the measurements for every hit channel. A source with no hits gets a single fill word in place of its measurements. Each word carries a 3-bit type code in its top bits, an even-parity bit and a link sync bit in bit 0, so a receiver can decode the stream one word at a time.

Measurements are fetched through a same-cycle lookup port. During the words of one hit, the block presents a source and channel number, and the surrounding logic returns four bytes: a time and a charge for each of two chips. The output is a valid/ready stream. Between events `out_valid_o` is low and the bus shows the null word. Putting the words onto the physical serial link is left to a later stage.

Top module: `evt_word_fmt`

## Requirements
- R1: Whenever no event is in progress, including during and right after reset, `out_valid_o` is 0 and `out_word_o` equals the null word 21'h000001.
- R2: Bit 0 of every emitted word is 1. Bits 20:18 carry the type: 111 trigger, 110 header, 101 full data, 011 data in the low byte, 010 fill.
- R3: A trigger seen while idle makes `out_valid_o` rise on the next cycle. The first word of the event is the trigger word 21'h1FFE01 (bits 20:9 all ones, bits 8:1 zero).
- R4: The second word is the header: type 110, the captured sync number in bits 16:9 and the word count in bits 8:1.
- R5: The word count is the number of words in the event after the trigger word, saturated at 255. With NCH channels per source that is 1 + 2·NCH/16 plus, for each source, three words per hit or one word when the source has no hits.
- R6: In every event word except the trigger word, bit 17 makes the parity of bits 20:1 even.
- R7: After the header come NCH/16 type-101 bitmap words per source, source 0 first. Each source starts with channel slice 15:0, carried in bits 16:1, and goes up in slices of 16.
- R8: Hits follow the bitmaps: all of source 0, then all of source 1, with channels in ascending order. Each hit produces three words:
  - a type-011 word with bits 16:9 zero and the channel number in bits 8:1;
  - a type-101 word holding chip-0 time in bits 16:9 and chip-1 time in bits 8:1;
  - a type-101 word holding chip-0 charge in bits 16:9 and chip-1 charge in bits 8:1.
- R9: During a hit's words `meas_src_o`/`meas_chan_o` name the hit, and `meas_data_i` is read as {chip-0 time, chip-1 time, chip-0 charge, chip-1 charge}, most significant byte first.
- R10: A source without hits contributes exactly one fill word, 21'h0A0001, in place of its hit words.
- R11: While `out_valid_o` is high and `out_ready_i` is low, the word is held unchanged and valid stays high.
- R12: A trigger that arrives during an event is ignored: the running event is unchanged and no extra event follows.
- R13: Bitmaps and sync number are sampled only in the cycle the trigger is accepted. Later input changes do not alter the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Trigger request, accepted only when idle |
| trig_sync_i | input | 8 | Event sync number, sampled with the trigger |
| bmap0_i | input | NCH | Hit bitmap of source 0 |
| bmap1_i | input | NCH | Hit bitmap of source 1 |
| meas_src_o | output | 1 | Source of the hit being formatted |
| meas_chan_o | output | $clog2(NCH) | Channel of the hit being formatted |
| meas_data_i | input | 32 | Measurement bytes for the named hit, same cycle |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Consumer ready |
| out_word_o | output | 21 | Output word |

## Verification
Every single-channel bitmap on each source is swept. This catches a reversed channel scan, a wrong source order or a misplaced channel field, because each of those puts a channel number or a measurement word in the wrong place. Events with no hits and events with every channel hit test the word count: a design that counts the trigger word, or counts three words for an empty source, gives a wrong header count. Random backpressure, triggers injected mid-event and input bitmaps scrambled right after capture expose a stream that advances while stalled, restarts on a second trigger or reads the live inputs instead of the captured copies.

// File: rtl/evt_fmt_pkg.sv
package evt_fmt_pkg;

  localparam int WORD_W = 21;
  localparam int NSRC   = 2;

  // Word type codes (bits 20:18)
  localparam logic [2:0] WT_FILL = 3'b010;
  localparam logic [2:0] WT_LOB  = 3'b011;
  localparam logic [2:0] WT_DATA = 3'b101;
  localparam logic [2:0] WT_HDR  = 3'b110;

  localparam logic [WORD_W-1:0] NULL_WORD = 21'h000001;
  localparam logic [WORD_W-1:0] TRIG_WORD = 21'h1FFE01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TRIG,
    ST_HDR,
    ST_BMAP,
    ST_CHAN,
    ST_TIME,
    ST_CHRG,
    ST_FILL
  } fmt_state_e;

  // Assemble a typed word: parity over type and payload, sync bit set.
  function automatic logic [WORD_W-1:0] fmt_word(input logic [2:0] wtype,
                                                 input logic [15:0] payload);
    logic par;
    par = ^{wtype, payload};
    return {wtype, par, payload, 1'b1};
  endfunction

endpackage

// File: rtl/evt_fmt_wcount.sv
module evt_fmt_wcount #(
  parameter int NCH = 32
) (
  input  logic [NCH-1:0] bm0_i,
  input  logic [NCH-1:0] bm1_i,
  output logic [7:0]     count_o
);
  import evt_fmt_pkg::*;

  localparam int NBW = NCH / 16;
  localparam int HW  = $clog2(NCH + 1);

  logic [NSRC-1:0][NCH-1:0] bm;
  logic [NSRC-1:0][15:0]    term;
  logic [15:0]              total;

  assign bm[0] = bm0_i;
  assign bm[1] = bm1_i;

  // Per-source contribution: three words per hit, or one fill word.
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic [HW-1:0] hits;
    always_comb begin
      hits = '0;
      for (int i = 0; i < NCH; i++) begin
        hits = hits + HW'(bm[s][i]);
      end
      if (hits == '0) term[s] = 16'd1;
      else            term[s] = 16'(hits) * 16'd3;
    end
  end

  always_comb begin
    total = 16'(1 + NSRC * NBW);
    for (int s = 0; s < NSRC; s++) begin
      total = total + term[s];
    end
    count_o = (total > 16'd255) ? 8'hFF : total[7:0];
  end

endmodule

// File: rtl/evt_fmt_lowbit.sv
module evt_fmt_lowbit #(
  parameter int NCH = 32,
  parameter int CW  = 5
) (
  input  logic [NCH-1:0] vec_i,
  output logic [CW-1:0]  idx_o,
  output logic [NCH-1:0] rest_o
);

  // Lowest set bit wins; rest_o drops that bit.
  always_comb begin
    idx_o = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = CW'(i);
    end
    rest_o = vec_i & (vec_i - NCH'(1));
  end

endmodule

// File: rtl/evt_fmt_seq.sv
module evt_fmt_seq #(
  parameter int NCH = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   trig_i,
  input  logic [7:0]             sync_i,
  input  logic [NCH-1:0]         bm0_i,
  input  logic [NCH-1:0]         bm1_i,
  input  logic [7:0]             count_i,
  input  logic                   ready_i,
  input  logic [NCH-1:0]         rest_i,
  output evt_fmt_pkg::fmt_state_e state_o,
  output logic                   src_o,
  output logic [((NCH/16) > 1 ? $clog2(NCH/16) : 1)-1:0] bidx_o,
  output logic [NCH-1:0]         rem_o,
  output logic [NCH-1:0]         bm0_o,
  output logic [NCH-1:0]         bm1_o,
  output logic [7:0]             sync_o,
  output logic [7:0]             count_o
);
  import evt_fmt_pkg::*;

  localparam int NBW = NCH / 16;
  localparam int BIW = (NBW > 1) ? $clog2(NBW) : 1;

  fmt_state_e     state_q, state_d;
  logic           src_q, src_d;
  logic [BIW-1:0] bidx_q, bidx_d;
  logic [NCH-1:0] rem_q, rem_d;
  logic [NCH-1:0] bm0_q, bm1_q;
  logic [7:0]     sync_q, count_q;
  logic           cap_en, fire, sect_end;

  assign cap_en = (state_q == ST_IDLE) && trig_i;
  assign fire   = (state_q != ST_IDLE) && ready_i;

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    src_d    = src_q;
    bidx_d   = bidx_q;
    rem_d    = rem_q;
    sect_end = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (trig_i) begin
          state_d = ST_TRIG;
          src_d   = 1'b0;
          bidx_d  = '0;
        end
      end
      ST_TRIG: if (fire) state_d = ST_HDR;
      ST_HDR:  if (fire) state_d = ST_BMAP;
      ST_BMAP: begin
        if (fire) begin
          if (bidx_q == BIW'(NBW - 1)) begin
            bidx_d = '0;
            if (src_q) begin
              src_d   = 1'b0;
              rem_d   = bm0_q;
              state_d = (bm0_q == '0) ? ST_FILL : ST_CHAN;
            end else begin
              src_d = 1'b1;
            end
          end else begin
            bidx_d = bidx_q + BIW'(1);
          end
        end
      end
      ST_CHAN: if (fire) state_d = ST_TIME;
      ST_TIME: if (fire) state_d = ST_CHRG;
      ST_CHRG: begin
        if (fire) begin
          rem_d = rest_i;
          if (rest_i == '0) sect_end = 1'b1;
          else              state_d  = ST_CHAN;
        end
      end
      ST_FILL: if (fire) sect_end = 1'b1;
      default: state_d = ST_IDLE;
    endcase
    if (sect_end) begin
      if (src_q) begin
        state_d = ST_IDLE;
      end else begin
        src_d   = 1'b1;
        rem_d   = bm1_q;
        state_d = (bm1_q == '0) ? ST_FILL : ST_CHAN;
      end
    end
  end

  // Sequencing registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      src_q   <= 1'b0;
      bidx_q  <= '0;
      rem_q   <= '0;
    end else begin
      state_q <= state_d;
      src_q   <= src_d;
      bidx_q  <= bidx_d;
      rem_q   <= rem_d;
    end
  end

  // Event capture registers, enabled only on an accepted trigger
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bm0_q   <= '0;
      bm1_q   <= '0;
      sync_q  <= '0;
      count_q <= '0;
    end else if (cap_en) begin
      bm0_q   <= bm0_i;
      bm1_q   <= bm1_i;
      sync_q  <= sync_i;
      count_q <= count_i;
    end
  end

  assign state_o = state_q;
  assign src_o   = src_q;
  assign bidx_o  = bidx_q;
  assign rem_o   = rem_q;
  assign bm0_o   = bm0_q;
  assign bm1_o   = bm1_q;
  assign sync_o  = sync_q;
  assign count_o = count_q;

endmodule

// File: rtl/evt_word_fmt.sv
module evt_word_fmt #(
  parameter int NCH = 32,
  parameter int CW  = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           trig_i,
  input  logic [7:0]     trig_sync_i,
  input  logic [NCH-1:0] bmap0_i,
  input  logic [NCH-1:0] bmap1_i,
  output logic           meas_src_o,
  output logic [CW-1:0]  meas_chan_o,
  input  logic [31:0]    meas_data_i,
  output logic           out_valid_o,
  input  logic           out_ready_i,
  output logic [20:0]    out_word_o
);
  import evt_fmt_pkg::*;

  localparam int NBW = NCH / 16;
  localparam int BIW = (NBW > 1) ? $clog2(NBW) : 1;

  fmt_state_e     state;
  logic           src;
  logic [BIW-1:0] bidx;
  logic [NCH-1:0] rem, rest, bm0_cap, bm1_cap, bm_sel;
  logic [7:0]     count_in, sync_cap, count_cap;
  logic [CW-1:0]  chan;
  logic [15:0]    slice;

  evt_fmt_wcount #(.NCH(NCH)) u_wcount (
    .bm0_i   (bmap0_i),
    .bm1_i   (bmap1_i),
    .count_o (count_in)
  );

  evt_fmt_lowbit #(.NCH(NCH), .CW(CW)) u_lowbit (
    .vec_i  (rem),
    .idx_o  (chan),
    .rest_o (rest)
  );

  evt_fmt_seq #(.NCH(NCH)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_i  (trig_i),
    .sync_i  (trig_sync_i),
    .bm0_i   (bmap0_i),
    .bm1_i   (bmap1_i),
    .count_i (count_in),
    .ready_i (out_ready_i),
    .rest_i  (rest),
    .state_o (state),
    .src_o   (src),
    .bidx_o  (bidx),
    .rem_o   (rem),
    .bm0_o   (bm0_cap),
    .bm1_o   (bm1_cap),
    .sync_o  (sync_cap),
    .count_o (count_cap)
  );

  assign bm_sel = src ? bm1_cap : bm0_cap;
  assign slice  = bm_sel[int'(bidx) * 16 +: 16];

  // Word assembly
  always_comb begin
    case (state)
      ST_TRIG: out_word_o = TRIG_WORD;
      ST_HDR:  out_word_o = fmt_word(WT_HDR, {sync_cap, count_cap});
      ST_BMAP: out_word_o = fmt_word(WT_DATA, slice);
      ST_CHAN: out_word_o = fmt_word(WT_LOB, {8'h00, 8'(chan)});
      ST_TIME: out_word_o = fmt_word(WT_DATA, meas_data_i[31:16]);
      ST_CHRG: out_word_o = fmt_word(WT_DATA, meas_data_i[15:0]);
      ST_FILL: out_word_o = fmt_word(WT_FILL, 16'h0000);
      default: out_word_o = NULL_WORD;
    endcase
  end

  assign out_valid_o = (state != ST_IDLE);
  assign meas_src_o  = src;
  assign meas_chan_o = chan;

endmodule

// File: rtl/evt_word_fmt_chk.sv
module evt_word_fmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        trig_i,
  input logic        out_valid_o,
  input logic        out_ready_i,
  input logic [20:0] out_word_o
);

  logic fire;
  assign fire = out_valid_o && out_ready_i;

  p_idle_null_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid_o |-> out_word_o == 21'h000001);

  p_sync_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_word_o[0]);

  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid_o && trig_i) |=> (out_valid_o && out_word_o == 21'h1FFE01));

  p_hdr_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_word_o[20:18] == 3'b111) |=> (out_valid_o && out_word_o[20:18] == 3'b110));

  p_even_parity_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_word_o[20:18] != 3'b111) |-> ^out_word_o[20:1] == 1'b0);

  p_fill_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_word_o[20:18] == 3'b010) |-> out_word_o[16:1] == 16'h0000);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_word_o)));

endmodule

bind evt_word_fmt evt_word_fmt_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .trig_i      (trig_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_word_o  (out_word_o)
);

// File: tb/evt_word_fmt_tb_top.sv
module evt_word_fmt_tb_top;

  localparam int NCH = 32;
  localparam int CW  = 5;
  localparam int NBW = NCH / 16;

  logic           clk = 1'b0;
  logic           rst_n, trig, out_ready, out_valid, meas_src;
  logic [7:0]     sync;
  logic [NCH-1:0] bm0, bm1;
  logic [CW-1:0]  meas_chan;
  logic [31:0]    meas_data;
  logic [20:0]    out_word;

  int          checks = 0;
  int          fails  = 0;
  logic [31:0] seed   = 32'h1234_5678;

  always #10 clk = ~clk;

  function automatic logic [31:0] mfun(input logic s, input int c);
    return {8'(c * 5 + (s ? 17 : 0) + 3), 8'(c * 11 + (s ? 29 : 0) + 7),
            8'(~(c * 3 + (s ? 1 : 0))), 8'(c ^ (s ? 8'hA5 : 8'h3C))};
  endfunction

  assign meas_data = mfun(meas_src, int'(meas_chan));

  evt_word_fmt #(.NCH(NCH)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_i      (trig),
    .trig_sync_i (sync),
    .bmap0_i     (bm0),
    .bmap1_i     (bm1),
    .meas_src_o  (meas_src),
    .meas_chan_o (meas_chan),
    .meas_data_i (meas_data),
    .out_valid_o (out_valid),
    .out_ready_i (out_ready),
    .out_word_o  (out_word)
  );

  logic [20:0] expw [0:255];
  int          exp_n;

  function automatic logic [20:0] mk(input logic [2:0] t, input logic [15:0] d);
    logic p;
    p = ^{t, d};
    return {t, p, d, 1'b1};
  endfunction

  task automatic step_seed();
    seed = seed * 32'd1664525 + 32'd1013904223;
  endtask

  task automatic build(input logic [NCH-1:0] b0, input logic [NCH-1:0] b1,
                       input logic [7:0] sy);
    logic [NCH-1:0] bs;
    logic [31:0]    m;
    int             cnt;
    exp_n = 0;
    expw[exp_n++] = 21'h1FFE01;
    exp_n++;                                  // header slot
    for (int s = 0; s < 2; s++) begin
      bs = (s == 1) ? b1 : b0;
      for (int k = 0; k < NBW; k++) expw[exp_n++] = mk(3'b101, bs[k*16 +: 16]);
    end
    for (int s = 0; s < 2; s++) begin
      bs = (s == 1) ? b1 : b0;
      if (bs == '0) expw[exp_n++] = 21'h0A0001;
      else begin
        for (int c = 0; c < NCH; c++) begin
          if (bs[c]) begin
            m = mfun(s[0], c);
            expw[exp_n++] = mk(3'b011, {8'h00, 8'(c)});
            expw[exp_n++] = mk(3'b101, m[31:16]);
            expw[exp_n++] = mk(3'b101, m[15:0]);
          end
        end
      end
    end
    cnt = (exp_n - 1 > 255) ? 255 : exp_n - 1;
    expw[1] = mk(3'b110, {sy, 8'(cnt)});
  endtask

  task automatic chk(input bit ok, input string tag, input logic [20:0] act,
                     input logic [20:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input int i);
    if (i == 0) return "R3";
    if (i == 1) return "R4";
    if (i < 2 + 2 * NBW) return "R7";
    if (expw[i][20:18] == 3'b010) return "R10";
    return "R8 R9";
  endfunction

  task automatic run_event(input logic [NCH-1:0] b0, input logic [NCH-1:0] b1,
                           input logic [7:0] sy, input int rmode,
                           input bit inj, input bit garb);
    int          idx;
    int          cyc;
    bit          stalled;
    logic [20:0] held;
    string       extra;
    extra = {inj ? " R12" : "", garb ? " R13" : ""};
    build(b0, b1, sy);
    @(negedge clk);
    trig = 1'b1; bm0 = b0; bm1 = b1; sync = sy; out_ready = 1'b0;
    @(negedge clk);
    trig = 1'b0;
    if (garb) begin
      step_seed();
      bm0 = ~b0; bm1 = seed; sync = ~sy;
    end
    idx = 0; cyc = 0; stalled = 0; held = '0;
    while (idx < exp_n && cyc < 5000) begin
      step_seed();
      out_ready = (rmode == 0) ? 1'b1 : seed[17];
      trig = inj && (idx == 3);
      if (inj && idx == 3) bm0 = seed;
      #1;
      if (stalled) chk(out_valid && out_word == held, "R11", out_word, held);
      if (!out_valid) begin
        chk(1'b0, {"R3 valid low mid-event", extra}, out_word, expw[idx]);
        stalled = 0;
      end else if (out_ready) begin
        chk(out_word == expw[idx], {tag_of(idx), extra}, out_word, expw[idx]);
        chk(out_word[0] == 1'b1, "R2", out_word, expw[idx]);
        if (idx > 0) chk(^out_word[20:1] == 1'b0, "R6", out_word, expw[idx]);
        if (idx == 1) chk(out_word[8:1] == expw[1][8:1], "R5", out_word, expw[1]);
        idx++;
        stalled = 0;
      end else begin
        stalled = 1;
        held    = out_word;
      end
      cyc++;
      @(negedge clk);
    end
    trig = 1'b0;
    out_ready = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(!out_valid && out_word == 21'h000001, {"R1 idle after event", extra},
          out_word, 21'h000001);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; trig = 1'b0; out_ready = 1'b0;
    bm0 = '0; bm1 = '0; sync = '0;
    repeat (3) @(negedge clk);
    #1 chk(!out_valid && out_word == 21'h000001, "R1 in reset", out_word, 21'h000001);
    @(negedge clk);
    rst_n = 1'b1;
    #1 chk(!out_valid && out_word == 21'h000001, "R1 after reset", out_word, 21'h000001);

    // Fixed corner events
    run_event('0, '0, 8'h00, 0, 0, 0);
    run_event(32'h0000_0001, '0, 8'h01, 0, 0, 0);
    run_event('0, 32'h8000_0000, 8'hFE, 1, 0, 0);
    run_event('1, '1, 8'h80, 1, 0, 0);
    run_event(32'hAAAA_5555, 32'h0001_8000, 8'h5A, 1, 1, 1);

    // Single-channel sweep on each source
    for (int c = 0; c < NCH; c++) begin
      run_event(NCH'(1) << c, '0, 8'(c), 0, 0, 0);
      run_event('0, NCH'(1) << c, 8'(c + 100), (c % 2), 0, (c % 3 == 0));
    end

    // Pseudo-random events with backpressure, injections and input scrambling
    for (int e = 0; e < 24; e++) begin
      logic [NCH-1:0] r0, r1;
      step_seed(); r0 = seed & {seed[7:0], seed[31:8]};
      step_seed(); r1 = (e % 4 == 0) ? '0 : (seed | {seed[0], seed[31:1]});
      run_event(r0, r1, 8'(e * 9 + 1), 1, (e % 2 == 0), (e % 3 == 1));
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule